// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit with Privilege Checking

This unit translates virtual addresses into physical addresses for both instruction fetches and data accesses. Each side owns a single-way table that is indexed by the low bits of the virtual page number. Every entry holds two 32-bit words. The match word carries the page tag and a valid flag. The translate word carries the page frame and six permission bits, split into user and supervisor groups. A lookup is issued with the access side, the load or store direction and the current privilege level. One cycle later the unit returns one of two results. The first is a physical address together with the rights it granted. The second is a classified fault: a miss when the tag differs or the entry is invalid, or a page fault when the rights are insufficient.

Software fills the tables through a write port. The port takes a side, an entry index, a word select and the data. When translation is switched off, every address passes through unchanged with full rights. On any fault the unit latches the faulting virtual address. It also pulses a signal that clears the core's load-link reservation.

Top module: `xlate_unit`

## Requirements
- R1: After reset, no response is valid, `rsp_fault` is 0, `fault_addr` is 0, `resv_clear` is 0, and every entry of both tables has match word 0 and translate word 0, so every translated lookup is a miss.
- R2: The entry index is `va[18:13]` (virtual page number = `va[31:13]`, 8 KiB pages, 64 entries per side). The instruction table (`req_instr`=1) and the data table (`req_instr`=0) are separate, and a write to one side never changes a lookup on the other.
- R3: A translated lookup hits only if `match[31:13]` equals `va[31:13]`. Otherwise `rsp_fault` is 1 (miss).
- R4: Match word bit 0 is the valid flag. A tag match with bit 0 clear gives `rsp_fault` = 1 (miss).
- R5: Translate word bits: 0 user-read, 1 user-write, 2 user-execute, 3 supervisor-read, 4 supervisor-write, 5 supervisor-execute. A fetch uses bit 5 when `super_mode`=1 and bit 2 otherwise. Without that right, `rsp_fault` is 2 (page fault).
- R6: A data access uses bits 3/4 (read/write) in supervisor mode and bits 0/1 in user mode. A load without read right or a store without write right gives `rsp_fault` = 2.
- R7: On a hit with sufficient rights, `rsp_pa` = {translate[31:13], va[12:0]} and `rsp_fault` = 0. `rsp_rights` is {exec, write, read}: {x,0,0} for fetches and {0,w,r} for data. On any fault, `rsp_pa` and `rsp_rights` are 0.
- R8: A request sampled at a clock edge gives `rsp_valid`=1 and `rsp_instr` equal to `req_instr` after that edge. With no request, `rsp_valid`=0 and `rsp_fault`=0.
- R9: `wr_trans`=0 writes the match word and `wr_trans`=1 writes the translate word. A write is seen by lookups issued in later cycles. A lookup in the same cycle as a write to its entry sees the old contents.
- R10: When a response carries a fault, `fault_addr` holds that request's virtual address and `resv_clear` is 1 for that cycle. Otherwise `fault_addr` holds its value and `resv_clear` is 0.
- R11: With `xlate_en`=0, `rsp_pa` = `va`, `rsp_rights` = 3'b111 and `rsp_fault` = 0, whatever the tables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | 1 translates, 0 passes addresses through |
| super_mode | input | 1 | 1 supervisor, 0 user privilege |
| req_valid | input | 1 | Lookup request |
| req_instr | input | 1 | 1 instruction side, 0 data side |
| req_store | input | 1 | Data side: 1 store, 0 load |
| req_va | input | 32 | Virtual address |
| wr_en | input | 1 | Table write strobe |
| wr_instr | input | 1 | Table written: 1 instruction, 0 data |
| wr_idx | input | 6 | Entry index written |
| wr_trans | input | 1 | 0 match word, 1 translate word |
| wr_data | input | 32 | Word written |
| rsp_valid | output | 1 | Response valid |
| rsp_instr | output | 1 | Side of the response |
| rsp_pa | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted {exec, write, read} |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 page fault |
| fault_addr | output | 32 | Last faulting virtual address |
| resv_clear | output | 1 | Clear load-link reservation pulse |

## Verification
A table write and a lookup of the same entry can fall in the same cycle, and the lookup must then see the old contents. The bench provokes this on purpose. In one case it writes a valid match word while it looks up that page, and expects a miss. In the next cycle it writes the translate word during a lookup, and expects a page fault from the old, empty rights. Only the cycle after that may hit. Random traffic also lands writes and lookups on a small pool of pages. The reference model in the bench computes each expectation before it applies the write of that cycle, so every such collision is judged.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 13;
  localparam int VPN_W  = WORD_W - OFS_W;

  // translate word permission bit positions
  localparam int TR_UR = 0;
  localparam int TR_UW = 1;
  localparam int TR_UX = 2;
  localparam int TR_SR = 3;
  localparam int TR_SW = 4;
  localparam int TR_SX = 5;
  localparam int MW_VALID = 0;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PAGE = 2'd2
  } fault_e;

  function automatic logic [VPN_W-1:0] page_of(input logic [WORD_W-1:0] a);
    return a[WORD_W-1:OFS_W];
  endfunction

  // rights returned as {exec, write, read}
  function automatic logic [2:0] grant(input logic [WORD_W-1:0] tw,
                                       input logic sup, input logic instr);
    logic [2:0] g;
    if (instr) g = {(sup ? tw[TR_SX] : tw[TR_UX]), 2'b00};
    else       g = {1'b0, (sup ? tw[TR_SW] : tw[TR_UW]),
                          (sup ? tw[TR_SR] : tw[TR_UR])};
    return g;
  endfunction

  function automatic logic [2:0] needed(input logic instr, input logic store);
    return instr ? 3'b100 : (store ? 3'b010 : 3'b001);
  endfunction

  function automatic logic [WORD_W-1:0] join_pa(input logic [WORD_W-1:0] tw,
                                                input logic [WORD_W-1:0] va);
    return {tw[WORD_W-1:OFS_W], va[OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic              wsel_trans,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rd_match,
  output logic [WORD_W-1:0] rd_trans
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mtab [DEPTH];
  logic [WORD_W-1:0] ttab [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mtab[i] <= '0;
        ttab[i] <= '0;
      end
    end else if (we) begin
      if (wsel_trans) ttab[widx] <= wdata;
      else            mtab[widx] <= wdata;
    end
  end

  // read before the edge: same-cycle write is not forwarded
  assign rd_match = mtab[ridx];
  assign rd_trans = ttab[ridx];
endmodule

// File: rtl/xlate_judge.sv
module xlate_judge
  import xlate_pkg::*;
(
  input  logic              xlate_en,
  input  logic              super_mode,
  input  logic              is_instr,
  input  logic              is_store,
  input  logic [WORD_W-1:0] va,
  input  logic [WORD_W-1:0] mword,
  input  logic [WORD_W-1:0] tword,
  output logic [WORD_W-1:0] pa,
  output logic [2:0]        rights,
  output logic [1:0]        fault,
  output logic              ev_hit,
  output logic              ev_miss,
  output logic              ev_perm
);
  logic       tag_ok;
  logic       ent_valid;
  logic [2:0] g;
  logic       perm_ok;
  logic       unused_bits;

  assign tag_ok    = (page_of(mword) == page_of(va));
  assign ent_valid = mword[MW_VALID];
  assign g         = grant(tword, super_mode, is_instr);
  assign perm_ok   = |(g & needed(is_instr, is_store));
  assign unused_bits = ^{tword[OFS_W-1:TR_SX+1], mword[OFS_W-1:MW_VALID+1]};

  always_comb begin
    pa      = '0;
    rights  = '0;
    fault   = FLT_NONE;
    ev_hit  = 1'b0;
    ev_miss = 1'b0;
    ev_perm = 1'b0;
    if (!xlate_en) begin
      pa     = va;
      rights = 3'b111;
    end else if (!tag_ok || !ent_valid) begin
      fault   = FLT_MISS;
      ev_miss = 1'b1;
    end else if (!perm_ok) begin
      fault   = FLT_PAGE;
      ev_perm = 1'b1;
    end else begin
      pa     = join_pa(tword, va);
      rights = g;
      ev_hit = 1'b1;
    end
  end
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int IIDX_W = 6,
  parameter int DIDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xlate_en,
  input  logic        super_mode,
  input  logic        req_valid,
  input  logic        req_instr,
  input  logic        req_store,
  input  logic [31:0] req_va,
  input  logic        wr_en,
  input  logic        wr_instr,
  input  logic [5:0]  wr_idx,
  input  logic        wr_trans,
  input  logic [31:0] wr_data,
  output logic        rsp_valid,
  output logic        rsp_instr,
  output logic [31:0] rsp_pa,
  output logic [2:0]  rsp_rights,
  output logic [1:0]  rsp_fault,
  output logic [31:0] fault_addr,
  output logic        resv_clear
);
  localparam int NSIDE = 2;   // 0 data, 1 instruction
  localparam int SIDE_IW [NSIDE] = '{DIDX_W, IIDX_W};

  logic [WORD_W-1:0] side_m [NSIDE];
  logic [WORD_W-1:0] side_t [NSIDE];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int IW = SIDE_IW[s];
    xlate_store #(.IDX_W(IW)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (wr_en && (wr_instr == 1'(s))),
      .widx       (wr_idx[IW-1:0]),
      .wsel_trans (wr_trans),
      .wdata      (wr_data),
      .ridx       (req_va[OFS_W+IW-1:OFS_W]),
      .rd_match   (side_m[s]),
      .rd_trans   (side_t[s])
    );
  end

  logic [WORD_W-1:0] j_pa;
  logic [2:0]        j_rights;
  logic [1:0]        j_fault;
  logic              j_hit, j_miss, j_perm;

  xlate_judge u_judge (
    .xlate_en   (xlate_en),
    .super_mode (super_mode),
    .is_instr   (req_instr),
    .is_store   (req_store),
    .va         (req_va),
    .mword      (side_m[req_instr]),
    .tword      (side_t[req_instr]),
    .pa         (j_pa),
    .rights     (j_rights),
    .fault      (j_fault),
    .ev_hit     (j_hit),
    .ev_miss    (j_miss),
    .ev_perm    (j_perm)
  );

  // named lookup events, qualified by the request
  logic lk_hit, lk_miss, lk_perm, lk_fault;
  assign lk_hit   = req_valid && j_hit;
  assign lk_miss  = req_valid && j_miss;
  assign lk_perm  = req_valid && j_perm;
  assign lk_fault = req_valid && (j_fault != FLT_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_instr  <= 1'b0;
      rsp_pa     <= '0;
      rsp_rights <= '0;
      rsp_fault  <= FLT_NONE;
      fault_addr <= '0;
      resv_clear <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_instr  <= req_instr;
      resv_clear <= lk_fault;
      if (req_valid) begin
        rsp_pa     <= j_pa;
        rsp_rights <= j_rights;
        rsp_fault  <= j_fault;
      end else begin
        rsp_pa     <= '0;
        rsp_rights <= '0;
        rsp_fault  <= FLT_NONE;
      end
      if (lk_fault) fault_addr <= req_va;
    end
  end
endmodule

// File: rtl/xlate_unit_chk.sv
module xlate_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlate_en,
  input logic        req_valid,
  input logic        req_instr,
  input logic        req_store,
  input logic [31:0] req_va,
  input logic        rsp_valid,
  input logic [31:0] rsp_pa,
  input logic [2:0]  rsp_rights,
  input logic [1:0]  rsp_fault,
  input logic [31:0] fault_addr,
  input logic        resv_clear,
  input logic        lk_hit,
  input logic        lk_miss,
  input logic        lk_perm
);
  // R8
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 2'd0));
  // R10
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (lk_miss || lk_perm) |=> fault_addr == $past(req_va));
  // R10
  fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == 2'd0) |-> $stable(fault_addr));
  // R10
  resv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clear |-> (rsp_valid && rsp_fault != 2'd0));
  // R11
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlate_en) |=>
      (rsp_pa == $past(req_va) && rsp_rights == 3'b111 && rsp_fault == 2'd0));
  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (rsp_pa == 32'd0 && rsp_rights == 3'd0));
  // R3
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_perm}));
  // R4
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> rsp_fault == 2'd1);
  // R5
  perm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_perm |=> rsp_fault == 2'd2);
  // R6
  store_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_instr && req_store) |=>
      (rsp_fault != 2'd0 || rsp_rights[1]));
  // R5
  exec_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_instr) |=> (rsp_fault != 2'd0 || rsp_rights[2]));
endmodule

bind xlate_unit xlate_unit_chk u_xlate_unit_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xlate_en   (xlate_en),
  .req_valid  (req_valid),
  .req_instr  (req_instr),
  .req_store  (req_store),
  .req_va     (req_va),
  .rsp_valid  (rsp_valid),
  .rsp_pa     (rsp_pa),
  .rsp_rights (rsp_rights),
  .rsp_fault  (rsp_fault),
  .fault_addr (fault_addr),
  .resv_clear (resv_clear),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_perm    (lk_perm)
);

// File: tb/test_xlate_unit.sv
`timescale 1ns/1ps
module test_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b0, super_mode = 1'b0;
  logic        req_valid = 1'b0, req_instr = 1'b0, req_store = 1'b0;
  logic [31:0] req_va = '0;
  logic        wr_en = 1'b0, wr_instr = 1'b0, wr_trans = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        rsp_valid, rsp_instr, resv_clear;
  logic [31:0] rsp_pa, fault_addr;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_fault;

  always #2.5 clk = ~clk;

  xlate_unit i_xlate_unit (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .super_mode(super_mode),
    .req_valid(req_valid), .req_instr(req_instr), .req_store(req_store),
    .req_va(req_va), .wr_en(wr_en), .wr_instr(wr_instr), .wr_idx(wr_idx),
    .wr_trans(wr_trans), .wr_data(wr_data), .rsp_valid(rsp_valid),
    .rsp_instr(rsp_instr), .rsp_pa(rsp_pa), .rsp_rights(rsp_rights),
    .rsp_fault(rsp_fault), .fault_addr(fault_addr), .resv_clear(resv_clear)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [31:0] bm [2][64];
  logic [31:0] bt [2][64];
  logic [31:0] e_fa = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; checks the response one negedge later
  task automatic apply(input logic en, input logic sup, input logic rv,
                       input logic ins, input logic st, input logic [31:0] va,
                       input logic we, input logic wins, input logic [5:0] wi,
                       input logic wt, input logic [31:0] wd, input string tag);
    logic [31:0] m, t, e_pa;
    logic [2:0]  g, e_r;
    logic [1:0]  e_f;
    logic        ok;
    string       tg;
    xlate_en = en; super_mode = sup; req_valid = rv; req_instr = ins;
    req_store = st; req_va = va; wr_en = we; wr_instr = wins; wr_idx = wi;
    wr_trans = wt; wr_data = wd;
    e_pa = '0; e_r = '0; e_f = 2'd0; tg = "R8";
    if (rv) begin
      if (!en) begin
        e_pa = va; e_r = 3'b111; tg = "R11";
      end else begin
        m = bm[ins][va[18:13]];
        t = bt[ins][va[18:13]];
        if ((m >> 13) != (va >> 13)) begin e_f = 2'd1; tg = "R3"; end
        else if (!m[0])              begin e_f = 2'd1; tg = "R4"; end
        else begin
          if (ins) begin
            g = {(sup ? t[5] : t[2]), 2'b00}; ok = g[2];
          end else begin
            g = {1'b0, (sup ? t[4] : t[1]), (sup ? t[3] : t[0])};
            ok = st ? g[1] : g[0];
          end
          if (!ok) begin e_f = 2'd2; tg = ins ? "R5" : "R6"; end
          else begin e_pa = {t[31:13], va[12:0]}; e_r = g; tg = "R7"; end
        end
      end
      if (e_f != 2'd0) e_fa = va;
    end
    if (tag != "") tg = tag;
    if (we) begin
      if (wt) bt[wins][wi] = wd;
      else    bm[wins][wi] = wd;
    end
    @(negedge clk);
    chk(rsp_valid == rv, "R8", "rsp_valid", 32'(rsp_valid), 32'(rv));
    if (rv) begin
      chk(rsp_instr == ins, "R8", "rsp_instr", 32'(rsp_instr), 32'(ins));
      chk(rsp_fault == e_f, tg, "rsp_fault", 32'(rsp_fault), 32'(e_f));
      chk(rsp_pa == e_pa, tg, "rsp_pa", rsp_pa, e_pa);
      chk(rsp_rights == e_r, tg, "rsp_rights", 32'(rsp_rights), 32'(e_r));
    end else begin
      chk(rsp_fault == 2'd0, "R8", "idle rsp_fault", 32'(rsp_fault), 32'd0);
    end
    chk(fault_addr == e_fa, "R10", "fault_addr", fault_addr, e_fa);
    chk(resv_clear == (rv && e_f != 2'd0), "R10", "resv_clear",
        32'(resv_clear), 32'(rv && e_f != 2'd0));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, tw, r, va, wd;
    logic [5:0]  wi;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 64; i++) begin bm[s][i] = '0; bt[s][i] = '0; end
    r = $urandom(32'd1357);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk(rsp_fault == 2'd0, "R1", "rsp_fault", 32'(rsp_fault), 32'd0);
    chk(fault_addr == 32'd0, "R1", "fault_addr", fault_addr, 32'd0);
    chk(resv_clear == 1'b0, "R1", "resv_clear", 32'(resv_clear), 32'd0);
    apply(1, 1, 1, 0, 0, 32'h0000_0000, 0, 0, 0, 0, 0, "R1");
    apply(1, 0, 1, 1, 0, 32'h1234_5678, 0, 0, 0, 0, 0, "R1");
    // R11 bypass with full rights
    apply(0, 0, 1, 0, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, "R11");
    apply(0, 1, 1, 1, 0, 32'h1234_5678, 0, 0, 0, 0, 0, "R11");
    // R9 same-cycle write sees old contents
    a  = 32'h0140_A123;
    tw = {19'h5A5A5, 7'd0, 6'b011001};
    apply(1, 0, 1, 0, 0, a, 1, 0, a[18:13], 0, {a[31:13], 13'd1}, "R9");
    apply(1, 0, 1, 0, 0, a, 1, 0, a[18:13], 1, tw, "R9");
    apply(1, 0, 1, 0, 0, a, 0, 0, 0, 0, 0, "R7");
    // R6 user store denied, supervisor store allowed
    apply(1, 0, 1, 0, 1, a, 0, 0, 0, 0, 0, "R6");
    apply(1, 1, 1, 0, 1, a, 0, 0, 0, 0, 0, "R6");
    // R2 instruction side untouched by data writes
    apply(1, 1, 1, 1, 0, a, 0, 0, 0, 0, 0, "R2");
    // R3 same index, other tag
    apply(1, 1, 1, 0, 0, a ^ 32'h0010_0000, 0, 0, 0, 0, 0, "R3");
    // R5 instruction entry: supervisor execute only
    apply(1, 0, 1, 0, 0, a, 1, 1, a[18:13], 0, {a[31:13], 13'd1}, "");
    apply(1, 0, 1, 0, 0, a, 1, 1, a[18:13], 1, {19'h0ABCD, 7'd0, 6'b100000}, "");
    apply(1, 0, 1, 1, 0, a, 0, 0, 0, 0, 0, "R5");
    apply(1, 1, 1, 1, 0, a, 0, 0, 0, 0, 0, "R5");
    // R2 data entry still intact after instruction writes
    apply(1, 0, 1, 0, 0, a, 0, 0, 0, 0, 0, "R2");
    // R4 invalidate keeps tag
    apply(1, 0, 0, 0, 0, a, 1, 0, a[18:13], 0, {a[31:13], 13'd0}, "");
    apply(1, 1, 1, 0, 0, a, 0, 0, 0, 0, 0, "R4");
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // random traffic on a small page pool
    for (int n = 0; n < 4000; n++) begin
      va = {13'($urandom % 3), 6'($urandom % 8), 13'($urandom)};
      wi = 6'($urandom % 8);
      if ($urandom % 2 == 0)
        wd = {13'($urandom % 3), wi, 12'($urandom), 1'(($urandom % 4) != 0)};
      else
        wd = $urandom;
      apply(($urandom % 16) != 0, 1'($urandom), ($urandom % 4) != 0,
            1'($urandom), 1'($urandom), va, ($urandom % 5) < 2,
            1'($urandom), wi, wd[0] ^ 1'($urandom), wd, "");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule